// File: doc/BRIEF.md
# Hub Downstream Port Enable Controller

This block holds the enable and speed state of the downstream ports of a USB hub repeater and turns that state into per-port forwarding gates. Firmware reaches it through an 8-bit register interface with two selects: one for the port-enable register and one for the port-speed register. Line-state decoding, packet detection and frame timing are done elsewhere. They arrive here as a packet-in-flight flag, a full-speed-traffic flag, an end-of-frame check strobe, and per-port non-idle, upstream-connected and suspend flags.

An enable request from firmware takes effect only at a packet boundary. If no packet is in flight, the port turns on at the next clock edge. Otherwise the request is held until the first cycle with no packet in flight. At the end-of-frame check point (EOF2), any enabled port that is babbling loses its enable bit and gives a one-cycle event pulse. A port is babbling if it shows non-idle downstream traffic, or if upstream connectivity to it is still open because no end-of-packet has arrived. A port forwards upstream traffic only when it is enabled and not suspended. A port marked low speed is also blocked while full-speed traffic is on the bus.

Top module: `hub_port_gate`

## Requirements
- R1: An active-low chip reset or a synchronous bus reset clears all enable bits, all speed bits, all held enable requests and all babble pulses.
- R2: Reading with the enable select shows the port enable bits in bits 0 to 3, and reading with the speed select shows the speed bits in bits 0 to 3. Bits 7 to 4 always read as zero, even after ones are written there. With neither select, the read data is zero.
- R3: Writing a 1 to bit p of the enable register while no packet is in flight sets port_en[p] at the next clock edge.
- R4: Writing a 1 to bit p of the enable register while a packet is in flight holds the request. port_en[p] stays 0 while the packet flag is high, and is set at the edge that ends the first cycle with the packet flag low.
- R5: Writing a 0 to bit p of the enable register clears port_en[p] at the next edge and cancels any held request for that port.
- R6: When eof2 is high and an enabled port p shows ds_nonidle[p], port_en[p] is cleared at the next edge and babble_evt[p] is 1 for exactly that one cycle.
- R7: When eof2 is high and an enabled port p shows us_connect[p], port_en[p] is cleared at the next edge and babble_evt[p] pulses for one cycle.
- R8: Activity flags have no effect without eof2, and eof2 has no effect on a disabled port. In both cases the enable is unchanged and no babble pulse appears.
- R9: If a firmware write to the enable register and a babble clear hit the same port in the same cycle, the babble clear wins and the port ends disabled. The other ports take the written value.
- R10: fwd_gate[p] is 1 exactly when port p is enabled, port_suspend[p] is 0, and it is not the case that port p is low speed while fs_traffic is 1.
- R11: Writing the speed register loads bit p into port_ls[p] at the next edge. A 1 marks a low-speed port and a 0 marks a full-speed port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| bus_reset | input | 1 | Synchronous USB bus reset |
| wr_en | input | 1 | Register write strobe |
| sel_enable | input | 1 | Selects the port-enable register |
| sel_speed | input | 1 | Selects the port-speed register |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for the selected register |
| pkt_active | input | 1 | A packet is being transmitted |
| fs_traffic | input | 1 | The current upstream traffic is full speed |
| eof2 | input | 1 | End-of-frame babble check strobe |
| ds_nonidle | input | 4 | Per-port non-idle downstream traffic |
| us_connect | input | 4 | Per-port upstream connectivity still open (no end-of-packet seen) |
| port_suspend | input | 4 | Per-port suspend flag |
| port_en | output | 4 | Current port enable bits |
| port_ls | output | 4 | Current port low-speed bits |
| fwd_gate | output | 4 | Per-port downstream forwarding gate |
| babble_evt | output | 4 | One-cycle pulse per port on a babble clear |

## Verification
Register-held results are due one edge after the cycle that causes them. These are port_en after a write with no packet in flight, port_ls after a speed write, and port_en and babble_evt after an eof2 babble check. A held enable request lands one edge after the first cycle with no packet in flight. fwd_gate and rdata are combinational, so they follow the current inputs and state in the same cycle. The bench changes inputs and compares outputs on the falling edge, so every check looks at the state the preceding rising edge produced. The reference model advances on the rising edge from the inputs driven half a cycle earlier.

// File: rtl/hub_port_gate.sv
module hub_port_gate #(
  parameter int NPORTS = 4,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_reset,
  input  logic              wr_en,
  input  logic              sel_enable,
  input  logic              sel_speed,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic              pkt_active,
  input  logic              fs_traffic,
  input  logic              eof2,
  input  logic [NPORTS-1:0] ds_nonidle,
  input  logic [NPORTS-1:0] us_connect,
  input  logic [NPORTS-1:0] port_suspend,
  output logic [NPORTS-1:0] port_en,
  output logic [NPORTS-1:0] port_ls,
  output logic [NPORTS-1:0] fwd_gate,
  output logic [NPORTS-1:0] babble_evt
);

  localparam int PAD = DW - NPORTS;

  logic [NPORTS-1:0] en_q, pend_q, ls_q, bev_q;

  wire               wr_enable = wr_en & sel_enable;
  wire               wr_speed  = wr_en & sel_speed;
  wire [NPORTS-1:0]  wr_bits   = wdata[NPORTS-1:0];
  wire [NPORTS-1:0]  set_req   = wr_enable ? wr_bits  : '0;
  wire [NPORTS-1:0]  clr_req   = wr_enable ? ~wr_bits : '0;

  wire [NPORTS-1:0]  babble    = {NPORTS{eof2}} & en_q & (ds_nonidle | us_connect);
  wire [NPORTS-1:0]  waiting   = (pend_q | set_req) & ~clr_req & ~en_q;
  wire [NPORTS-1:0]  promote   = pkt_active ? '0 : waiting;
  wire [NPORTS-1:0]  en_d      = ((en_q & ~clr_req) | promote) & ~babble;
  wire [NPORTS-1:0]  pend_d    = waiting & ~promote & ~babble;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
      ls_q   <= '0;
      bev_q  <= '0;
    end else if (bus_reset) begin
      en_q   <= '0;
      pend_q <= '0;
      ls_q   <= '0;
      bev_q  <= '0;
    end else begin
      en_q   <= en_d;
      pend_q <= pend_d;
      bev_q  <= babble;
      if (wr_speed) ls_q <= wr_bits;
    end
  end

  assign port_en    = en_q;
  assign port_ls    = ls_q;
  assign babble_evt = bev_q;
  assign fwd_gate   = en_q & ~port_suspend & ~(ls_q & {NPORTS{fs_traffic}});

  always_comb begin
    rdata = '0;
    if (sel_enable)     rdata = {{PAD{1'b0}}, en_q};
    else if (sel_speed) rdata = {{PAD{1'b0}}, ls_q};
  end

  p_bus_reset_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (port_en == '0 && port_ls == '0 && babble_evt == '0));

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DW-1:NPORTS] == '0);

  p_no_enable_mid_packet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_active |=> ((port_en & ~$past(port_en)) == '0));

  p_babble_leaves_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (babble_evt & port_en) == '0);

  p_babble_needs_eof2_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !eof2 |=> babble_evt == '0);

  p_suspend_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_gate & (port_suspend | ~port_en)) == '0);

endmodule

// File: tb/hub_port_gate_bench.sv
module hub_port_gate_bench;
  logic clk = 0;
  logic rst_n = 0;
  logic bus_reset = 0, wr_en = 0, sel_enable = 0, sel_speed = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic pkt_active = 0, fs_traffic = 0, eof2 = 0;
  logic [3:0] ds_nonidle = 0, us_connect = 0, port_suspend = 0;
  logic [3:0] port_en, port_ls, fwd_gate, babble_evt;

  int vectors = 0, miscompares = 0, cycles = 0;
  int m_en[4], m_pend[4], m_ls[4], m_bev[4];

  always #5 clk = ~clk;

  hub_port_gate u_hub_port_gate (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .wr_en(wr_en),
    .sel_enable(sel_enable), .sel_speed(sel_speed), .wdata(wdata), .rdata(rdata),
    .pkt_active(pkt_active), .fs_traffic(fs_traffic), .eof2(eof2),
    .ds_nonidle(ds_nonidle), .us_connect(us_connect), .port_suspend(port_suspend),
    .port_en(port_en), .port_ls(port_ls), .fwd_gate(fwd_gate), .babble_evt(babble_evt)
  );

  function automatic logic [3:0] pack(input int a[4]);
    logic [3:0] v;
    for (int i = 0; i < 4; i++) v[i] = (a[i] != 0);
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || bus_reset) begin
      for (int p = 0; p < 4; p++) begin m_en[p] = 0; m_pend[p] = 0; m_ls[p] = 0; m_bev[p] = 0; end
    end else begin
      for (int p = 0; p < 4; p++) begin
        int want_on, want_off, bab, waiting, up;
        want_on  = wr_en && sel_enable && wdata[p];
        want_off = wr_en && sel_enable && !wdata[p];
        bab      = eof2 && m_en[p] && (ds_nonidle[p] || us_connect[p]);
        waiting  = (m_pend[p] || want_on) && !want_off && !m_en[p];
        up       = waiting && !pkt_active;
        m_bev[p] = bab;
        if (bab) begin m_en[p] = 0; m_pend[p] = 0; end
        else begin
          m_en[p]   = (m_en[p] && !want_off) || up;
          m_pend[p] = waiting && !up;
        end
        if (wr_en && sel_speed) m_ls[p] = wdata[p];
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic [3:0] e, l, f;
    logic [7:0] r;
    cycles++;
    if (rst_n) begin
      e = pack(m_en); l = pack(m_ls);
      f = e & ~port_suspend & ~(l & {4{fs_traffic}});
      r = sel_enable ? {4'h0, e} : (sel_speed ? {4'h0, l} : 8'h00);
      chk("R3 port_en model", {4'h0, port_en}, {4'h0, e});
      chk("R11 port_ls model", {4'h0, port_ls}, {4'h0, l});
      chk("R6 babble_evt model", {4'h0, babble_evt}, {4'h0, pack(m_bev)});
      chk("R10 fwd_gate model", {4'h0, fwd_gate}, {4'h0, f});
      chk("R2 rdata model", rdata, r);
    end
    if (cycles > 100000) begin
      miscompares++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic wr(input logic en_sel, input logic [7:0] d);
    sel_enable = en_sel; sel_speed = !en_sel; wdata = d; wr_en = 1;
    tick();
    wr_en = 0; sel_enable = 0; sel_speed = 0;
  endtask

  initial begin
    tick(); tick();
    rst_n = 1;
    tick();
    chk("R1 en after reset", {4'h0, port_en}, 8'h00);
    chk("R1 ls after reset", {4'h0, port_ls}, 8'h00);

    wr(1, 8'h01);
    chk("R3 idle enable", {4'h0, port_en}, 8'h01);

    pkt_active = 1;
    wr(1, 8'hF3);
    chk("R4 held mid packet", {4'h0, port_en}, 8'h01);
    sel_enable = 1; #1;
    chk("R2 reserved enable bits", rdata, 8'h01);
    sel_enable = 0;
    tick(); tick();
    chk("R4 still held", {4'h0, port_en}, 8'h01);
    pkt_active = 0;
    tick();
    chk("R4 applied after packet", {4'h0, port_en}, 8'h03);

    wr(0, 8'hA4);
    chk("R11 speed load", {4'h0, port_ls}, 8'h04);
    sel_speed = 1; #1;
    chk("R2 speed readback", rdata, 8'h04);
    sel_speed = 0; #1;
    chk("R2 no select reads zero", rdata, 8'h00);

    wr(1, 8'h0F);
    fs_traffic = 1; port_suspend = 4'b0010; #1;
    chk("R10 fs blocks low speed", {4'h0, fwd_gate}, 8'h09);
    fs_traffic = 0; #1;
    chk("R10 low speed passes", {4'h0, fwd_gate}, 8'h0D);
    port_suspend = 0;

    wr(1, 8'h0B);
    chk("R5 disable", {4'h0, port_en}, 8'h0B);

    ds_nonidle = 4'hF; us_connect = 4'hF;
    tick();
    chk("R8 no eof2 no effect", {4'h0, port_en}, 8'h0B);
    chk("R8 no pulse", {4'h0, babble_evt}, 8'h00);
    ds_nonidle = 4'b0100; us_connect = 0; eof2 = 1;
    tick();
    eof2 = 0; ds_nonidle = 0;
    chk("R8 disabled port ignored", {4'h0, port_en}, 8'h0B);
    chk("R8 no pulse disabled", {4'h0, babble_evt}, 8'h00);

    eof2 = 1; ds_nonidle = 4'b0001;
    tick();
    eof2 = 0; ds_nonidle = 0;
    chk("R6 nonidle clear", {4'h0, port_en}, 8'h0A);
    chk("R6 pulse", {4'h0, babble_evt}, 8'h01);
    tick();
    chk("R6 pulse one cycle", {4'h0, babble_evt}, 8'h00);

    eof2 = 1; us_connect = 4'b0010;
    tick();
    eof2 = 0; us_connect = 0;
    chk("R7 connect clear", {4'h0, port_en}, 8'h08);
    chk("R7 pulse", {4'h0, babble_evt}, 8'h02);

    eof2 = 1; ds_nonidle = 4'b1000;
    wr(1, 8'h0F);
    eof2 = 0; ds_nonidle = 0;
    chk("R9 babble wins", {4'h0, port_en}, 8'h07);
    chk("R9 pulse", {4'h0, babble_evt}, 8'h08);

    pkt_active = 1;
    wr(1, 8'h08);
    chk("R5 clears others", {4'h0, port_en}, 8'h00);
    wr(1, 8'h00);
    pkt_active = 0;
    tick(); tick();
    chk("R5 held request cancelled", {4'h0, port_en}, 8'h00);

    wr(1, 8'h0F);
    wr(0, 8'h0F);
    bus_reset = 1;
    tick();
    bus_reset = 0;
    chk("R1 bus reset en", {4'h0, port_en}, 8'h00);
    chk("R1 bus reset ls", {4'h0, port_ls}, 8'h00);
    tick(); tick();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule